// File: doc/BRIEF.md
# Modem Control and Status Unit with Loopback

This block holds the modem-control register and the modem-status register of a 16550-style serial port. Software writes the control register to drive the four control outputs (two handshake lines and two general-purpose outputs) and to select loopback. The status register carries the present state of the four status lines (clear-to-send, data-set-ready, ring indicator, carrier detect) in its upper nibble and a sticky change flag for each line in its lower nibble.

In normal mode the status lines follow the external inputs after a parameterised synchroniser. In loopback mode they are derived from the control bits instead, and the external inputs are disregarded. Three of the change flags record any change of their line. The ring-indicator flag records only a falling edge. Reading the status register returns its value and clears the change flags. A level request goes to the port's interrupt prioritiser while any change flag is set and the modem-status interrupt enable is on.

Top module: `mdm_loop_unit`

## Requirements
- R1: A write to offset 4 (control register) stores only wdata[4:0] (bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 loopback), which appears on ctl_out at the next clock edge. A read of offset 4 returns zeros in bits 7:5.
- R2: While loopback (control bit 4) is set, the status line bits are RTS to CTS (status bit 4), DTR to DSR (bit 5), OUT1 to RI (bit 6) and OUT2 to DCD (bit 7). They take effect one clock edge after the control register changes.
- R3: While loopback is clear, each external input reaches its status bit SYNC_STAGES+1 clock edges after it changes. While loopback is set, the external inputs have no effect on the status register.
- R4: Any change of CTS, DSR or DCD between consecutive status updates sets change flag bit 0, 1 or 3 respectively.
- R5: Change flag bit 2 (ring) is set only when RI goes from 1 to 0. A rise of RI leaves it unchanged.
- R6: Change flags stay set across later status updates until the status register is read.
- R7: A read of offset 6 returns {lines[3:0], flags[3:0]} on rdata at the next edge and clears the flags at that edge. A flag raised at that same edge survives the read.
- R8: msi_req is high exactly while any change flag is set and msi_en is high, in the same cycle.
- R9: Writes to offset 6 have no effect on the status register or on the control register.
- R10: After reset, ctl_out, rdata, the status register and msi_req are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered, held between reads |
| msi_en | input | 1 | Modem-status interrupt enable |
| ext_cts | input | 1 | External clear-to-send |
| ext_dsr | input | 1 | External data-set-ready |
| ext_ri | input | 1 | External ring indicator |
| ext_dcd | input | 1 | External carrier detect |
| ctl_out | output | 5 | Control register contents |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
A control write shows on ctl_out one edge later. Looped-back status follows one edge after that. An external input change reaches the status register SYNC_STAGES+1 edges after it is driven. Read data lands one edge after the read strobe, and msi_req follows the flags in the same cycle. The bench steps its reference model at each rising edge and compares every output at the falling edge. Directed reads wait several idle cycles so that every pending update has settled. One case places the read strobe on exactly the edge where a new change is detected, to show that the read returns the old value and the new flag survives.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned MCR_W      = 5;
  localparam int unsigned LINE_W     = 4;
  localparam int unsigned BIT_DTR    = 0;
  localparam int unsigned BIT_RTS    = 1;
  localparam int unsigned BIT_OUT1   = 2;
  localparam int unsigned BIT_OUT2   = 3;
  localparam int unsigned BIT_LOOP   = 4;

  // Order matches status bits 7..4 and change flags 3..0.
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;
endpackage

// File: rtl/mdm_in_sync.sv
module mdm_in_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stg_q [STAGES];
      logic [W-1:0] stg_d [STAGES];

      always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
          stg_d[i] = stg_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) begin
            stg_q[i] <= '0;
          end
        end else begin
          for (int i = 0; i < STAGES; i++) begin
            stg_q[i] <= stg_d[i];
          end
        end
      end

      assign q = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [MCR_W-1:0] wval,
  output logic [MCR_W-1:0] mcr_q
);
  logic [MCR_W-1:0] mcr_d;
  logic             mcr_en;

  always_comb begin
    mcr_en = wr_hit;
    mcr_d  = wval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcr_q <= '0;
    end else if (mcr_en) begin
      mcr_q <= mcr_d;
    end
  end
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mdm_lines_t        src,
  input  logic              rd_hit,
  output mdm_lines_t        lines_q,
  output logic [LINE_W-1:0] delta_q
);
  mdm_lines_t        lines_d;
  logic [LINE_W-1:0] delta_d;
  logic [LINE_W-1:0] set_v;
  logic              lines_en;
  logic              delta_en;

  always_comb begin
    set_v[0] = src.cts ^ lines_q.cts;
    set_v[1] = src.dsr ^ lines_q.dsr;
    set_v[2] = lines_q.ri & ~src.ri;
    set_v[3] = src.dcd ^ lines_q.dcd;
    lines_en = (src != lines_q);
    lines_d  = src;
    delta_en = rd_hit | (|set_v);
    delta_d  = (rd_hit ? '0 : delta_q) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= '0;
    end else if (lines_en) begin
      lines_q <= lines_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delta_q <= '0;
    end else if (delta_en) begin
      delta_q <= delta_d;
    end
  end
endmodule

// File: rtl/mdm_loop_unit.sv
module mdm_loop_unit
  import mdm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MCR_ADDR    = 4,
  parameter int unsigned MSR_ADDR    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              msi_en,
  input  logic              ext_cts,
  input  logic              ext_dsr,
  input  logic              ext_ri,
  input  logic              ext_dcd,
  output logic [MCR_W-1:0]  ctl_out,
  output logic              msi_req
);
  localparam int unsigned MSR_W = 2 * LINE_W;
  localparam logic [ADDR_W-1:0] A_MCR = ADDR_W'(MCR_ADDR);
  localparam logic [ADDR_W-1:0] A_MSR = ADDR_W'(MSR_ADDR);

  logic              hit_mcr;
  logic              hit_msr;
  logic              wr_mcr;
  logic              rd_msr;
  logic [MCR_W-1:0]  mcr_q;
  mdm_lines_t        ext_raw;
  mdm_lines_t        ext_syn;
  mdm_lines_t        loop_src;
  mdm_lines_t        sel_src;
  mdm_lines_t        msr_lines;
  logic [LINE_W-1:0] msr_delta;
  logic [DATA_W-1:0] rdata_d;
  logic              unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:MCR_W];

  always_comb begin
    hit_mcr = (addr == A_MCR);
    hit_msr = (addr == A_MSR);
    wr_mcr  = wr_en & hit_mcr;
    rd_msr  = rd_en & hit_msr;
  end

  mdm_ctl_reg u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_mcr),
    .wval   (wdata[MCR_W-1:0]),
    .mcr_q  (mcr_q)
  );

  always_comb begin
    ext_raw.cts = ext_cts;
    ext_raw.dsr = ext_dsr;
    ext_raw.ri  = ext_ri;
    ext_raw.dcd = ext_dcd;
  end

  mdm_in_sync #(
    .STAGES (SYNC_STAGES),
    .W      (LINE_W)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_raw),
    .q     (ext_syn)
  );

  always_comb begin
    loop_src.cts = mcr_q[BIT_RTS];
    loop_src.dsr = mcr_q[BIT_DTR];
    loop_src.ri  = mcr_q[BIT_OUT1];
    loop_src.dcd = mcr_q[BIT_OUT2];
    sel_src      = mcr_q[BIT_LOOP] ? loop_src : ext_syn;
  end

  mdm_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (sel_src),
    .rd_hit  (rd_msr),
    .lines_q (msr_lines),
    .delta_q (msr_delta)
  );

  always_comb begin
    rdata_d = '0;
    if (hit_mcr) begin
      rdata_d[MCR_W-1:0] = mcr_q;
    end else if (hit_msr) begin
      rdata_d[MSR_W-1:0] = {msr_lines, msr_delta};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rdata_d;
    end
  end

  assign ctl_out = mcr_q;
  assign msi_req = msi_en & (|msr_delta);
endmodule

// File: rtl/mdm_loop_chk.sv
module mdm_loop_chk
  import mdm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MCR_ADDR = 4,
  parameter int unsigned MSR_ADDR = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              msi_en,
  input logic [MCR_W-1:0]  ctl_out,
  input logic              msi_req,
  input mdm_lines_t        lines,
  input logic [LINE_W-1:0] delta
);
  localparam logic [ADDR_W-1:0] A_MCR = ADDR_W'(MCR_ADDR);
  localparam logic [ADDR_W-1:0] A_MSR = ADDR_W'(MSR_ADDR);

  p_mcr_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MCR) |=> (ctl_out == $past(wdata[MCR_W-1:0])));

  p_loop_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_out[BIT_LOOP]) |->
      (lines == {$past(ctl_out[BIT_OUT2]), $past(ctl_out[BIT_OUT1]),
                 $past(ctl_out[BIT_DTR]), $past(ctl_out[BIT_RTS])}));

  p_cts_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lines.cts != $past(lines.cts)) |-> delta[0]);

  p_ri_rise_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(lines.ri) && lines.ri && !$past(delta[2])) |-> !delta[2]);

  p_read_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_MSR) |=>
      (rdata[2*LINE_W-1:0] == {$past(lines), $past(delta)}));

  p_req_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_req && !(rd_en && addr == A_MSR)) |=> (msi_en ? msi_req : 1'b1));

  p_msr_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MSR) |=> $stable(ctl_out));
endmodule

bind mdm_loop_unit mdm_loop_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .MCR_ADDR (MCR_ADDR),
  .MSR_ADDR (MSR_ADDR)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .msi_en  (msi_en),
  .ctl_out (ctl_out),
  .msi_req (msi_req),
  .lines   (msr_lines),
  .delta   (msr_delta)
);

// File: tb/sim_mdm_loop_unit.sv
`timescale 1ns/1ps
module sim_mdm_loop_unit;
  localparam int SYNC = 2;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic       rd_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       msi_en;
  logic       ext_cts, ext_dsr, ext_ri, ext_dcd;
  logic [4:0] ctl_out;
  logic       msi_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  mdm_loop_unit #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .msi_en(msi_en), .ext_cts(ext_cts),
    .ext_dsr(ext_dsr), .ext_ri(ext_ri), .ext_dcd(ext_dcd),
    .ctl_out(ctl_out), .msi_req(msi_req)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // Reference model: behavioural, stepped at each rising edge.
  logic [4:0] m_mcr;
  logic [3:0] m_lines;  // {dcd, ri, dsr, cts}
  logic [3:0] m_flags;
  logic [7:0] m_rdata;
  logic [3:0] m_pipe[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mcr = 0; m_lines = 0; m_flags = 0; m_rdata = 0;
      m_pipe.delete();
      for (int i = 0; i < SYNC; i++) m_pipe.push_back(4'h0);
    end else begin
      logic [3:0] src, fl;
      if (m_mcr[4]) src = {m_mcr[3], m_mcr[2], m_mcr[0], m_mcr[1]};
      else          src = m_pipe[0];
      fl = 0;
      fl[0] = src[0] != m_lines[0];
      fl[1] = src[1] != m_lines[1];
      fl[2] = m_lines[2] && !src[2];
      fl[3] = src[3] != m_lines[3];
      if (rd_en) begin
        if (addr == 3'd4)      m_rdata = {3'b000, m_mcr};
        else if (addr == 3'd6) m_rdata = {m_lines, m_flags};
        else                   m_rdata = 8'h00;
      end
      if (rd_en && addr == 3'd6) m_flags = 0;
      m_flags = m_flags | fl;
      m_lines = src;
      if (wr_en && addr == 3'd4) m_mcr = wdata[4:0];
      void'(m_pipe.pop_front());
      m_pipe.push_back({ext_dcd, ext_ri, ext_dsr, ext_cts});
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({3'b0, ctl_out}, {3'b0, m_mcr}, "R1 cycle ctl_out");
      chk({7'b0, msi_req}, {7'b0, msi_en && (m_flags != 0)}, "R8 cycle msi_req");
      chk(rdata, m_rdata, "R7 cycle rdata");
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    chk(rdata, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; msi_en = 1;
    ext_cts = 0; ext_dsr = 0; ext_ri = 0; ext_dcd = 0;
    idle(3);
    rst_n = 1;
    idle(1);
    // R10 reset state
    chk(rdata, 8'h00, "R10 rdata");
    chk({3'b0, ctl_out}, 8'h00, "R10 ctl_out");
    chk({7'b0, msi_req}, 8'h00, "R10 msi_req");
    rd_chk(3'd6, 8'h00, "R10 status");

    // R1 upper bits dropped; R2 loopback mapping; R4 change flags
    wr(3'd4, 8'hFF);
    idle(4);
    chk({3'b0, ctl_out}, 8'h1F, "R1 ctl_out");
    rd_chk(3'd4, 8'h1F, "R1 read control");
    chk({7'b0, msi_req}, 8'h01, "R8 request on");
    rd_chk(3'd6, 8'hFB, "R2 R4 loop status");
    idle(2);
    rd_chk(3'd6, 8'hF0, "R7 flags cleared");
    chk({7'b0, msi_req}, 8'h00, "R8 request off");

    // R5 ring fall sets flag, rise does not
    wr(3'd4, 8'h1B);
    idle(4);
    rd_chk(3'd6, 8'hB4, "R5 ring fall");
    wr(3'd4, 8'h1F);
    idle(4);
    rd_chk(3'd6, 8'hF0, "R5 ring rise");

    // R3 external inputs ignored in loopback
    @(negedge clk); ext_cts = 1; ext_dsr = 1; ext_ri = 1; ext_dcd = 1;
    idle(6);
    rd_chk(3'd6, 8'hF0, "R3 loopback ignores inputs");
    wr(3'd4, 8'h0F);
    idle(5);
    rd_chk(3'd6, 8'hF0, "R3 normal mode lines");
    chk({3'b0, ctl_out}, 8'h0F, "R1 loop cleared");

    // R9 status writes ignored
    wr(3'd6, 8'h00);
    idle(3);
    rd_chk(3'd6, 8'hF0, "R9 status untouched");
    rd_chk(3'd4, 8'h0F, "R9 control untouched");

    // R4 R5 R6 external edges
    @(negedge clk); ext_cts = 0;
    idle(5);
    rd_chk(3'd6, 8'hE1, "R4 cts change");
    @(negedge clk); ext_ri = 0;
    idle(5);
    rd_chk(3'd6, 8'hA4, "R5 ext ring fall");
    @(negedge clk); ext_ri = 1;
    idle(5);
    rd_chk(3'd6, 8'hE0, "R5 ext ring rise");
    @(negedge clk); ext_dcd = 0;
    idle(3);
    @(negedge clk); ext_dcd = 1;
    idle(3);
    @(negedge clk); ext_dcd = 0;
    idle(5);
    rd_chk(3'd6, 8'h68, "R6 flag held across updates");

    // R8 enable gating
    @(negedge clk); msi_en = 0; ext_dsr = 0;
    idle(5);
    chk({7'b0, msi_req}, 8'h00, "R8 gated off");
    @(negedge clk); msi_en = 1;
    @(negedge clk);
    chk({7'b0, msi_req}, 8'h01, "R8 gated on");
    rd_chk(3'd6, 8'h42, "R4 dsr change");

    // R7 read on the same edge a change lands
    @(negedge clk); ext_cts = 1;
    @(negedge clk);
    @(negedge clk); rd_en = 1; addr = 3'd6;
    @(negedge clk); rd_en = 0;
    chk(rdata, 8'h40, "R7 same-edge read old value");
    idle(2);
    rd_chk(3'd6, 8'h51, "R7 same-edge flag survives");

    idle(4);
    finish_run();
  end
endmodule